// File: doc/BRIEF.md
# Burst Address Counter Register

This block holds the word address that one port presents to a synchronous memory array. On each rising clock edge it can take a new address from the external bus, advance its own value by one, or return to zero. In all other cycles it keeps its value. With this behaviour the memory can read or write a run of consecutive words while the address bus stays idle. The counter covers the whole array. After the highest address it continues at address zero, so a burst can cross the top of memory without a new external address.

The three control inputs are active low. When more than one is asserted on the same edge, the clear input has the highest priority, then the address strobe, then the count enable. A synchronous, active-high reset also puts the counter at zero. The output comes straight from the address register, so no combinational path runs from any input to the output.

Top module: `bac_top`

## Requirements
- R1: When `rst` is high at a rising edge, `addr` is zero after that edge, whatever the control inputs are.
- R2: When `clear_n` is low at a rising edge (and `rst` is low), `addr` becomes zero, even if `strobe_n` or `count_n` is also low.
- R3: When `strobe_n` is low and `clear_n` is high at a rising edge, `addr` takes the value of `ext_addr`, even if `count_n` is also low.
- R4: When only `count_n` is low among the three controls, `addr` increases by one at the rising edge.
- R5: Counting from the all-ones address (0xFFFF at the default width of 16) gives zero on the next edge. The counter wraps over the full 2^AW word space.
- R6: When `clear_n`, `strobe_n` and `count_n` are all high, `addr` keeps its value, even while `ext_addr` changes.
- R7: While the counter is counting (only `count_n` low), `ext_addr` has no effect on `addr`.
- R8: `addr` is a register output. It changes only at a rising edge of `clk`, and its width is the parameter AW (default 16, 64K words; 17 gives 128K words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | AW | Address from the external bus |
| strobe_n | input | 1 | Loads `ext_addr` when low |
| count_n | input | 1 | Advances the address by one when low |
| clear_n | input | 1 | Returns the address to zero when low |
| addr | output | AW | Current word address sent to the array |

## Verification
A wrong counter value appears on `addr` one edge after the cycle that caused it. The bench compares `addr` with its reference on every clock, so the fault is seen in the same cycle that it shows at the port. A wrong priority between the controls shows up only in cycles where two or more controls are asserted together. The sequences therefore combine clear with strobe, and strobe with count. A carry fault that is missing or cut short can be seen only at the all-ones address, so one burst is run across the wrap point. A path through which `ext_addr` leaks into `addr` shows up only when `ext_addr` changes during hold or count cycles, so `ext_addr` is changed in those cycles.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_ZERO = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_ctrl.sv
module bac_ctrl
  import bac_pkg::*;
(
  input  logic    strobe_n,
  input  logic    count_n,
  input  logic    clear_n,
  output bac_op_e op
);
  // Fixed priority: clear over load over step (R2, R3, R4)
  always_comb begin
    if (!clear_n)       op = OP_ZERO;
    else if (!strobe_n) op = OP_LOAD;
    else if (!count_n)  op = OP_STEP;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int AW = 16
) (
  input  bac_op_e        op,
  input  logic [AW-1:0]  cur,
  input  logic [AW-1:0]  ext_addr,
  output logic [AW-1:0]  nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // Modulo-2^AW increment gives wrap across the full array (R5)
  always_comb begin
    case (op)
      OP_ZERO: nxt = '0;
      OP_LOAD: nxt = ext_addr;
      OP_STEP: nxt = cur + ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  logic past_rst_q = 1'b0;
  always_ff @(posedge clk) past_rst_q <= rst;

  // R1: register is zero one edge after reset
  always_ff @(posedge clk) begin
    if (past_rst_q) begin
      a_r1_reset_zero: assert (q == '0) else $error("R1 reset value");
    end
  end
endmodule

// File: rtl/bac_top.sv
module bac_top
  import bac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          count_n,
  input  logic          clear_n,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  bac_op_e       op;
  logic [AW-1:0] nxt;

  bac_ctrl ctrl_i (
    .strobe_n (strobe_n),
    .count_n  (count_n),
    .clear_n  (clear_n),
    .op       (op)
  );

  bac_next #(.AW(AW)) next_i (
    .op       (op),
    .cur      (addr),
    .ext_addr (ext_addr),
    .nxt      (nxt)
  );

  bac_reg #(.AW(AW)) reg_i (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (addr)
  );

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> addr == '0);

  a_r3_load_ext: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !strobe_n) |=> addr == $past(ext_addr));

  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (clear_n && strobe_n && !count_n && addr != TOP_ADDR) |=>
      addr == $past(addr) + AW'(1));

  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (clear_n && strobe_n && !count_n && addr == TOP_ADDR) |=> addr == '0);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (clear_n && strobe_n && count_n) |=> $stable(addr));
endmodule

// File: tb/bac_top_tb.sv
module bac_top_tb_top;
  localparam int AW = 16;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          count_n = 1'b1;
  logic          clear_n = 1'b1;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  int exp_addr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bac_top #(.AW(AW)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .count_n  (count_n),
    .clear_n  (clear_n),
    .addr     (addr)
  );

  // Reference model, evaluated at every rising edge from the driven inputs
  always @(posedge clk) begin
    if (rst)            exp_addr = 0;
    else if (!clear_n)  exp_addr = 0;
    else if (!strobe_n) exp_addr = int'(ext_addr);
    else if (!count_n)  exp_addr = (exp_addr + 1) & MASK;
  end

  task automatic check(input string tag);
    total++;
    if (int'(addr) != exp_addr) begin
      bad++;
      $display("FAIL %s: addr=%h expected=%h", tag, addr, exp_addr[AW-1:0]);
    end
  endtask

  // Drive inputs after the falling edge, compare after the next rising edge
  task automatic cyc(input logic r, input logic s, input logic c, input logic z,
                     input logic [AW-1:0] ea, input string tag);
    @(negedge clk);
    rst = r; strobe_n = s; count_n = c; clear_n = z; ext_addr = ea;
    @(posedge clk);
    #2;
    check(tag);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: expected=done actual=hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with every control asserted
    cyc(1, 0, 0, 0, 16'hABCD, "R1");
    cyc(1, 1, 1, 1, 16'h1111, "R1");
    // R6: hold while the bus toggles
    cyc(0, 1, 1, 1, 16'h5555, "R6");
    cyc(0, 1, 1, 1, 16'hAAAA, "R6");
    // R3: load
    cyc(0, 0, 1, 1, 16'h1234, "R3");
    cyc(0, 1, 1, 1, 16'h0000, "R6");
    // R4 and R7: count while the bus changes
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 16'(i * 16'h0F0F), "R7");
    cyc(0, 1, 0, 1, 16'h0000, "R4");
    // R3: load beats count
    cyc(0, 0, 0, 1, 16'h7000, "R3");
    // R2: clear beats strobe and count
    cyc(0, 0, 0, 0, 16'h4242, "R2");
    cyc(0, 0, 1, 1, 16'h0042, "R3");
    cyc(0, 1, 1, 0, 16'h0000, "R2");
    // R5: wrap across the top of the array
    cyc(0, 0, 1, 1, 16'hFFFD, "R3");
    cyc(0, 1, 0, 1, 16'h0000, "R4");
    cyc(0, 1, 0, 1, 16'h0000, "R4");
    cyc(0, 1, 0, 1, 16'h0000, "R5");
    cyc(0, 1, 0, 1, 16'h0000, "R5");
    // R8: address only changes at an edge; inputs changed mid-cycle
    @(negedge clk);
    count_n = 1'b0; ext_addr = 16'h9999;
    #3;
    total++;
    if (int'(addr) != exp_addr) begin
      bad++;
      $display("FAIL R8: addr=%h expected=%h", addr, exp_addr[AW-1:0]);
    end
    count_n = 1'b1;
    // R1: reset in the middle of a burst
    cyc(0, 1, 0, 1, 16'h0000, "R4");
    cyc(1, 1, 0, 1, 16'h0000, "R1");
    // Mixed random stimulus against the reference model
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 50) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
          ($urandom % 8) != 0, 16'($urandom), "MIX");
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule